// File: doc/BRIEF.md
# Bulk Erase Sequencer with Byte Verification

This block is a host-side controller that erases an entire command-driven flash memory and confirms that every byte is blank. After a start request it enables the high programming voltage and waits for it to settle. It then issues erase pulses over a simple write/read strobe bus. Between pulses it walks the address space upward and reads each byte back under the verify command. A byte that does not read FFh triggers another erase pulse, and checking then continues at that same byte. Addresses that already passed are not checked again.

A counter limits the total number of erase pulses across the whole run. When the walk reaches the end, the sequencer sends the reset command, drops the high voltage and pulses `done_o`. When the limit is exhausted, it sends the reset command, drops the voltage and pulses `fail_o`, with the offending byte on `fail_addr_o`. Every wait is a parameterised clock-cycle count.

States: `ST_IDLE`, `ST_HV_RAMP` (voltage settling), `ST_SETUP_WR` and `ST_ERASE_WR` (the two halves of an erase pulse), `ST_ERASE_WAIT`, `ST_VERIFY_WR`, `ST_VERIFY_WAIT`, `ST_READ`, `ST_RESET_WR` and `ST_REPORT`. The transitions are:
- idle→ramp on start.
- ramp→setup after the settle time.
- setup→erase→erase-wait.
- erase-wait→verify after the erase time.
- verify→verify-wait→read after the verify time.
- read→verify (byte blank, more addresses).
- read→setup (byte not blank, pulses left).
- read→reset (last byte blank, or limit reached).
- reset→report→idle.

Top module: `erase_sequencer`

## Requirements
- R1: After reset the block is idle: `busy_o`, `hv_en_o`, `fl_we_o`, `fl_re_o`, `done_o` and `fail_o` are all low.
- R2: An accepted start raises `hv_en_o` and `busy_o` in the next cycle. The first bus write follows HV_CYC cycles after the start edge. `hv_en_o` stays high during every bus strobe.
- R3: Each erase pulse is two writes of 20h in consecutive cycles. The first pulse is issued right after the voltage settles.
- R4: ERASE_CYC+1 cycles after the second 20h write, the verify command A0h is written at the current address.
- R5: VERIFY_CYC+1 cycles after the verify write, a read strobe is issued at the same address. `fl_rdata_i` is sampled in that cycle.
- R6: When the byte read is FFh and it is not the last address, the next cycle writes A0h at the address plus one, with no erase pulse in between.
- R7: When the byte read is not FFh and the pulse limit is not reached, the next cycle starts a new erase pulse. Verification then resumes at the same address, not at zero.
- R8: When the last address (all ones) reads FFh, the next cycle writes the reset command FFh. One cycle later `done_o` pulses with `hv_en_o` already low.
- R9: The run never issues more than PULSE_LIMIT erase pulses. A non-blank read after the last allowed pulse writes FFh, and then pulses `fail_o` with `hv_en_o` low and `fail_addr_o` equal to the failing address.
- R10: `done_o` and `fail_o` are single-cycle pulses and never high together. `busy_o` stays high from the cycle after the start edge through the report cycle.
- R11: A start request while `busy_o` is high is ignored: the bus sequence and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a bulk erase |
| busy_o | output | 1 | Sequence in progress |
| hv_en_o | output | 1 | Enable for the high programming voltage |
| fl_addr_o | output | AW | Flash byte address |
| fl_wdata_o | output | 8 | Command byte for a write strobe |
| fl_we_o | output | 1 | Single-cycle write strobe |
| fl_re_o | output | 1 | Single-cycle read strobe |
| fl_rdata_i | input | 8 | Byte returned during a read strobe |
| done_o | output | 1 | Pulse: all bytes verified blank |
| fail_o | output | 1 | Pulse: pulse limit exhausted |
| fail_addr_o | output | AW | Address of the failing byte, valid with `fail_o` |

## Verification
Every bus event is due a fixed number of cycles after the previous one:
- The first 20h write comes HV_CYC cycles after the start edge.
- The second 20h write comes one cycle after the first.
- The verify write comes ERASE_CYC+1 cycles after the second 20h.
- The read comes VERIFY_CYC+1 cycles after the verify write.
- The next verify, erase or reset write comes one cycle after a read.
- The report pulse comes one cycle after the reset write.

The bench derives these gaps from the requirements and stores each one with its expected event. A monitor counts cycles at the falling edge and compares the measured distance between consecutive events against the stored gap. Any extra, missing or late strobe is therefore reported.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HV_RAMP,
        ST_SETUP_WR,
        ST_ERASE_WR,
        ST_ERASE_WAIT,
        ST_VERIFY_WR,
        ST_VERIFY_WAIT,
        ST_READ,
        ST_RESET_WR,
        ST_REPORT
    } erase_state_e;

    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [TW-1:0] lim_i,
    output logic          hit_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (!hit_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = (cnt_q == lim_i);

endmodule

// File: rtl/erase_seq_addr.sv
module erase_seq_addr #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr_i) begin
            addr_q <= '0;
        end else if (step_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;
    assign last_o = &addr_q;

    // R6: the controller never steps past the top address
    a_r6_no_step_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o);

endmodule

// File: rtl/erase_seq_pulses.sv
module erase_seq_pulses #(
    parameter int LIMIT = 1000,
    localparam int PW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit_o = (cnt_q == PW'(LIMIT));

    // R9: no erase pulse is started once the budget is spent
    a_r9_no_pulse_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !at_limit_o);

endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int AW          = 18,
    parameter int HV_CYC      = 2000,
    parameter int ERASE_CYC   = 1000000,
    parameter int VERIFY_CYC  = 600,
    parameter int PULSE_LIMIT = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          hv_en_o,
    output logic [AW-1:0] fl_addr_o,
    output logic [7:0]    fl_wdata_o,
    output logic          fl_we_o,
    output logic          fl_re_o,
    input  logic [7:0]    fl_rdata_i,
    output logic          done_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o
);
    localparam int MAX_A = (HV_CYC > ERASE_CYC) ? HV_CYC : ERASE_CYC;
    localparam int MAX_W = (MAX_A > VERIFY_CYC) ? MAX_A : VERIFY_CYC;
    localparam int TW    = $clog2(MAX_W + 1);

    erase_state_e  state_q, state_d;
    logic          failed_q, failed_d;
    logic          tmr_clr, tmr_hit;
    logic [TW-1:0] tmr_lim;
    logic          addr_clr, addr_step, addr_last;
    logic          pul_inc, at_limit;
    logic          byte_blank;
    logic [AW-1:0] addr;

    erase_seq_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .lim_i (tmr_lim),
        .hit_o (tmr_hit)
    );

    erase_seq_addr #(.AW(AW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (addr_clr),
        .step_i (addr_step),
        .addr_o (addr),
        .last_o (addr_last)
    );

    erase_seq_pulses #(.LIMIT(PULSE_LIMIT)) u_pulses (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (addr_clr),
        .inc_i      (pul_inc),
        .at_limit_o (at_limit)
    );

    assign byte_blank = (fl_rdata_i == BYTE_BLANK);

    // wait length for the current state, minus one
    always_comb begin
        unique case (state_q)
            ST_HV_RAMP:     tmr_lim = TW'(HV_CYC - 1);
            ST_ERASE_WAIT:  tmr_lim = TW'(ERASE_CYC - 1);
            ST_VERIFY_WAIT: tmr_lim = TW'(VERIFY_CYC - 1);
            default:        tmr_lim = '0;
        endcase
    end

    // next state
    always_comb begin
        state_d   = state_q;
        failed_d  = failed_q;
        addr_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_HV_RAMP;
                    failed_d = 1'b0;
                end
            end
            ST_HV_RAMP:     if (tmr_hit) state_d = ST_SETUP_WR;
            ST_SETUP_WR:    state_d = ST_ERASE_WR;
            ST_ERASE_WR:    state_d = ST_ERASE_WAIT;
            ST_ERASE_WAIT:  if (tmr_hit) state_d = ST_VERIFY_WR;
            ST_VERIFY_WR:   state_d = ST_VERIFY_WAIT;
            ST_VERIFY_WAIT: if (tmr_hit) state_d = ST_READ;
            ST_READ: begin
                if (byte_blank) begin
                    if (addr_last) begin
                        state_d = ST_RESET_WR;
                    end else begin
                        state_d   = ST_VERIFY_WR;
                        addr_step = 1'b1;
                    end
                end else if (at_limit) begin
                    state_d  = ST_RESET_WR;
                    failed_d = 1'b1;
                end else begin
                    state_d = ST_SETUP_WR;
                end
            end
            ST_RESET_WR:    state_d = ST_REPORT;
            ST_REPORT:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr  = (state_d != state_q);
    assign addr_clr = (state_q == ST_IDLE) && start_i;
    assign pul_inc  = (state_q == ST_ERASE_WR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            failed_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            failed_q <= failed_d;
        end
    end

    // outputs decoded from the state
    always_comb begin
        fl_we_o    = 1'b0;
        fl_re_o    = 1'b0;
        fl_wdata_o = 8'h00;
        done_o     = 1'b0;
        fail_o     = 1'b0;
        hv_en_o    = 1'b1;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                hv_en_o = 1'b0;
                busy_o  = 1'b0;
            end
            ST_SETUP_WR, ST_ERASE_WR: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = CMD_ERASE;
            end
            ST_VERIFY_WR: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = CMD_VERIFY;
            end
            ST_READ: fl_re_o = 1'b1;
            ST_RESET_WR: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = CMD_RESET;
            end
            ST_REPORT: begin
                hv_en_o = 1'b0;
                done_o  = !failed_q;
                fail_o  = failed_q;
            end
            default: ;
        endcase
    end

    assign fl_addr_o   = addr;
    assign fail_addr_o = addr;

    // R2: high voltage present on every strobe
    a_r2_hv_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_o || fl_re_o) |-> hv_en_o);
    // R3: the erase setup write is followed by the erase start write
    a_r3_erase_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP_WR) |=> (fl_we_o && fl_wdata_o == CMD_ERASE));
    // R5: a read strobe only follows the verify wait
    a_r5_read_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re_o |-> ($past(state_q) == ST_VERIFY_WAIT));
    // R7: non-blank byte with budget left restarts an erase pulse
    a_r7_retry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_re_o && !byte_blank && !at_limit) |=> (fl_we_o && fl_wdata_o == CMD_ERASE));
    // R8: report happens with high voltage removed
    a_r8_report_hv_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !hv_en_o);
    // R10: single-cycle, exclusive result pulses
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    // R11: a start seen mid-run does not end the run
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o && !fail_o) |=> busy_o);

endmodule

// File: tb/erase_sequencer_bench.sv
module erase_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 3;
    localparam int NB    = 1 << AW;
    localparam int HV    = 5;
    localparam int EW    = 7;
    localparam int VW    = 3;
    localparam int LIM   = 4;
    localparam int WDOG  = 20000;

    localparam int K_WR = 0, K_RD = 1, K_DONE = 2, K_FAIL = 3;

    typedef struct {
        int    kind;
        int    addr;
        int    data;
        int    gap;
        string req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          busy_o, hv_en_o, fl_we_o, fl_re_o, done_o, fail_o;
    logic [AW-1:0] fl_addr_o, fail_addr_o;
    logic [7:0]    fl_wdata_o, fl_rdata_i;

    item_t q[$];
    int    need [NB];
    int    erases = 0;
    int    base = 0;
    bit    prev20 = 1'b0;
    int    cyc = 0;
    int    t_last = 0;
    bit    busy_prev = 1'b0;
    int    d_checks = 0, d_errors = 0;
    int    m_checks = 0, m_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    erase_sequencer #(
        .AW(AW), .HV_CYC(HV), .ERASE_CYC(EW), .VERIFY_CYC(VW), .PULSE_LIMIT(LIM)
    ) u_erase_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .hv_en_o(hv_en_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
        .fl_we_o(fl_we_o), .fl_re_o(fl_re_o), .fl_rdata_i(fl_rdata_i),
        .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o)
    );

    // flash model: a byte turns blank once enough erase pulses have landed
    assign fl_rdata_i = ((erases - base) >= need[fl_addr_o]) ? 8'hFF : 8'h5A;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fl_we_o) begin
            if (fl_wdata_o == 8'h20) begin
                if (prev20) begin
                    erases <= erases + 1;
                    prev20 <= 1'b0;
                end else begin
                    prev20 <= 1'b1;
                end
            end else begin
                prev20 <= 1'b0;
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", d_checks + m_checks, d_errors + m_errors);
    endtask

    task automatic dcheck(bit ok, string req, string what, int act, int exp);
        d_checks++;
        if (!ok) begin
            d_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare each bus event and its cycle gap
    always @(negedge clk) begin
        if (cyc > WDOG) begin
            m_checks++;
            m_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            summary();
            $finish;
        end
        if (rst_n) begin
            if (busy_o && !busy_prev) t_last = cyc;
            busy_prev = busy_o;
            if (fl_we_o || fl_re_o || done_o || fail_o) begin
                int kind;
                kind = fl_we_o ? K_WR : fl_re_o ? K_RD : done_o ? K_DONE : K_FAIL;
                m_checks++;
                if (q.size() == 0) begin
                    m_errors++;
                    $display("FAIL R11 unexpected event actual=%0d expected=%0d", kind, -1);
                end else begin
                    item_t it;
                    bit ok;
                    it = q.pop_front();
                    ok = (kind == it.kind) && ((cyc - t_last) == it.gap);
                    if (kind == K_WR)
                        ok = ok && (fl_wdata_o == it.data[7:0]) && (fl_addr_o == it.addr[AW-1:0]);
                    if (kind == K_RD)
                        ok = ok && (fl_addr_o == it.addr[AW-1:0]);
                    if (kind == K_FAIL)
                        ok = ok && (fail_addr_o == it.addr[AW-1:0]);
                    if (kind == K_WR || kind == K_RD) ok = ok && hv_en_o;
                    else ok = ok && !hv_en_o && !(done_o && fail_o);
                    if (!ok) begin
                        m_errors++;
                        $display("FAIL %s kind/addr/data/gap actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                                 it.req, kind, fl_re_o ? fl_addr_o : (kind == K_FAIL ? fail_addr_o : fl_addr_o),
                                 fl_wdata_o, cyc - t_last, it.kind, it.addr, it.data, it.gap);
                    end
                end
                t_last = cyc;
            end
        end
    end

    task automatic push(int kind, int addr, int data, int gap, string req);
        item_t it;
        it.kind = kind; it.addr = addr; it.data = data; it.gap = gap; it.req = req;
        q.push_back(it);
    endtask

    // expected event list, derived from the requirements
    task automatic plan_run();
        int  pulses = 1;
        bit  after_erase = 1'b1;
        push(K_WR, 0, 8'h20, HV, "R2");
        push(K_WR, 0, 8'h20, 1, "R3");
        for (int a = 0; a < NB; a++) begin
            forever begin
                push(K_WR, a, 8'hA0, after_erase ? EW + 1 : 1, after_erase ? "R4" : "R6");
                push(K_RD, a, 0, VW + 1, "R5");
                if (pulses >= need[a]) begin
                    after_erase = 1'b0;
                    break;
                end
                if (pulses == LIM) begin
                    push(K_WR, a, 8'hFF, 1, "R9");
                    push(K_FAIL, a, 0, 1, "R9");
                    return;
                end
                push(K_WR, a, 8'h20, 1, "R7");
                push(K_WR, a, 8'h20, 1, "R7");
                pulses++;
                after_erase = 1'b1;
            end
        end
        push(K_WR, NB - 1, 8'hFF, 1, "R8");
        push(K_DONE, 0, 0, 1, "R8");
    endtask

    task automatic run(int poke_at);
        base = erases;
        plan_run();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        dcheck(busy_o && hv_en_o, "R2", "busy/hv after start", busy_o, 1);
        if (poke_at > 0) begin
            repeat (poke_at) @(negedge clk);
            dcheck(busy_o, "R10", "busy mid-run", busy_o, 1);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        dcheck(!busy_o && !hv_en_o, "R10", "idle after report", busy_o, 0);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) need[i] = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        dcheck(!busy_o && !hv_en_o, "R1", "busy/hv in reset", {busy_o, hv_en_o}, 0);
        dcheck(!fl_we_o && !fl_re_o, "R1", "strobes in reset", {fl_we_o, fl_re_o}, 0);
        dcheck(!done_o && !fail_o, "R1", "results in reset", {done_o, fail_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        dcheck(!busy_o && !hv_en_o, "R1", "idle after reset", busy_o, 0);

        // all bytes blank after one pulse
        run(0);
        // retries resume at the failing byte; a mid-run start is ignored (R11)
        need[3] = 3; need[6] = 2;
        run(40);
        // exactly at the pulse budget still passes (R9 boundary)
        for (int i = 0; i < NB; i++) need[i] = 1;
        need[2] = LIM;
        run(0);
        // budget exhausted at byte 5
        need[2] = 1; need[5] = LIM + 5;
        run(25);
        // a clean run afterwards
        for (int i = 0; i < NB; i++) need[i] = 1;
        need[NB - 1] = 2;
        run(0);

        summary();
        $finish;
    end

endmodule